// File: doc/BRIEF.md
# Triggered vertical ramp generator

This block produces the digital vertical sawtooth for a raster display together with its blanking interval. It has no timebase of its own. A field starts only when a rising edge on the external vertical sync input is accepted. On acceptance, three things happen together:

- the ramp drops to zero (flyback);
- a blanking flag rises for a fixed number of clocks;
- a one-clock field-start strobe is issued.

Sync edges that arrive while blanking is active are discarded. When blanking ends, the ramp climbs again by adding a slope value on every clock. If no further trigger arrives, the ramp stops at full scale.

The slope comes from a slow amplitude loop. At each accepted trigger, the ramp value reached is compared with a target peak, and the slope moves by one step towards the value that would hit the target. The slope saturates at programmable limits. As a result, the peak height settles near the target at any steady field rate. The restart moment is set only by the blanking length and never by the loop.

Top module: `vramp_trig`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ramp_out` is 0 and `blank_out` and `field_start` are 0. The slope starts at SLOPE_INIT.
- R2: Without an accepted trigger and with blanking low, `ramp_out` grows by the current slope on every clock and saturates at 2^RAMP_W-1, where it stays.
- R3: `sync_in` passes through SYNC_STAGES flops, and a 0-to-1 transition counts as a trigger. With the default two stages, a level first sampled high at clock edge k is accepted at edge k+2. After that edge `field_start` is high for exactly one cycle, `blank_out` is high and `ramp_out` is 0.
- R4: `blank_out` stays high for exactly BLANK_CYC cycles after an accepted trigger, and `ramp_out` is 0 throughout.
- R5: A sync rising edge seen while `blank_out` is high produces no strobe and changes neither the blanking width nor the ramp.
- R6: j cycles after `blank_out` falls (j = 0 on the first low cycle), `ramp_out` equals min(j × slope, 2^RAMP_W-1).
- R7: At an accepted trigger the peak is the `ramp_out` value in that cycle. The slope rises by 1 if the peak is below TARGET, falls by 1 if above, and is unchanged if equal. The new slope is used from the next field on.
- R8: The slope never leaves [SLOPE_MIN, SLOPE_MAX]. A step that would pass a limit leaves the slope at that limit.
- R9: For a steady field period, the peak settles within one slope step of TARGET, independently of that period, as long as the target is reachable inside the slope limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous vertical sync trigger |
| ramp_out | output | RAMP_W | Vertical sawtooth value |
| blank_out | output | 1 | Blanking flag, high during flyback |
| field_start | output | 1 | One-clock strobe on each accepted trigger |

## Verification
The properties assume the following about the inputs:
- `rst` is synchronous and held for at least one edge at start-up.
- `sync_in` is a plain level that only the synchroniser samples.
- BLANK_CYC is at least one cycle.

The bench changes `sync_in` only on falling clock edges. In some fields it pulses sync again inside the blanking window to exercise the lockout. It chooses field periods such that every peak, and therefore every slope step, follows from arithmetic on the period and the expected slope. Some field periods drive the slope into both of its limits. Others make it settle at two different field rates.

// File: rtl/vramp_pkg.sv
package vramp_pkg;

  // Add inc to acc and clip at lim.
  function automatic int unsigned sat_accum(input int unsigned acc,
                                            input int unsigned inc,
                                            input int unsigned lim);
    longint unsigned sum;
    sum = {32'd0, acc} + {32'd0, inc};
    if (sum > {32'd0, lim}) return lim;
    return sum[31:0];
  endfunction

  // Move the slope one step towards the value that would hit target.
  function automatic int unsigned slope_nudge(input int unsigned s,
                                              input int unsigned peak,
                                              input int unsigned target,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (peak < target) return (s >= hi) ? hi : s + 1;
    if (peak > target) return (s <= lo) ? lo : s - 1;
    return s;
  endfunction

endpackage

// File: rtl/vr_sync_edge.sv
module vr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/vr_blank_gate.sv
module vr_blank_gate #(
  parameter int unsigned BLANK_CYC = 1100
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic accept,
  output logic blank
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          blank_q;

  assign accept = rise & ~blank_q;
  assign blank  = blank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept) begin
      blank_q <= 1'b1;
      cnt_q   <= LOAD;
    end else if (blank_q) begin
      if (cnt_q == '0) blank_q <= 1'b0;
      else             cnt_q   <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/vr_ramp_acc.sv
module vr_ramp_acc
  import vramp_pkg::*;
#(
  parameter int unsigned RAMP_W  = 16,
  parameter int unsigned SLOPE_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               blank,
  input  logic [SLOPE_W-1:0] slope,
  output logic [RAMP_W-1:0]  ramp
);
  localparam int unsigned RAMP_MAX = (32'd1 << RAMP_W) - 32'd1;

  logic [RAMP_W-1:0] ramp_q;
  int unsigned       next_v;

  always_comb next_v = sat_accum(32'(ramp_q), 32'(slope), RAMP_MAX);

  always_ff @(posedge clk) begin
    if (rst)                  ramp_q <= '0;
    else if (accept || blank) ramp_q <= '0;
    else                      ramp_q <= next_v[RAMP_W-1:0];
  end

  assign ramp = ramp_q;
endmodule

// File: rtl/vr_slope_loop.sv
module vr_slope_loop
  import vramp_pkg::*;
#(
  parameter int unsigned RAMP_W     = 16,
  parameter int unsigned SLOPE_W    = 10,
  parameter int unsigned TARGET     = 50000,
  parameter int unsigned SLOPE_INIT = 64,
  parameter int unsigned SLOPE_MIN  = 1,
  parameter int unsigned SLOPE_MAX  = 1023
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [RAMP_W-1:0]  peak,
  output logic [SLOPE_W-1:0] slope
);
  logic [SLOPE_W-1:0] slope_q;
  int unsigned        nxt;

  always_comb nxt = slope_nudge(32'(slope_q), 32'(peak), TARGET, SLOPE_MIN, SLOPE_MAX);

  always_ff @(posedge clk) begin
    if (rst)         slope_q <= SLOPE_W'(SLOPE_INIT);
    else if (accept) slope_q <= nxt[SLOPE_W-1:0];
  end

  assign slope = slope_q;
endmodule

// File: rtl/vramp_trig.sv
module vramp_trig #(
  parameter int unsigned RAMP_W      = 16,
  parameter int unsigned SLOPE_W     = 10,
  parameter int unsigned BLANK_CYC   = 1100,
  parameter int unsigned TARGET      = 50000,
  parameter int unsigned SLOPE_INIT  = 64,
  parameter int unsigned SLOPE_MIN   = 1,
  parameter int unsigned SLOPE_MAX   = 1023,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  output logic [RAMP_W-1:0] ramp_out,
  output logic              blank_out,
  output logic              field_start
);
  // Named internal events, used by the bound checker.
  logic               sync_rise;
  logic               accept;
  logic [SLOPE_W-1:0] slope_q;
  logic               fs_q;

  vr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sync_in), .rise(sync_rise)
  );

  vr_blank_gate #(.BLANK_CYC(BLANK_CYC)) u_gate (
    .clk(clk), .rst(rst), .rise(sync_rise), .accept(accept), .blank(blank_out)
  );

  vr_ramp_acc #(.RAMP_W(RAMP_W), .SLOPE_W(SLOPE_W)) u_acc (
    .clk(clk), .rst(rst), .accept(accept), .blank(blank_out),
    .slope(slope_q), .ramp(ramp_out)
  );

  vr_slope_loop #(
    .RAMP_W(RAMP_W), .SLOPE_W(SLOPE_W), .TARGET(TARGET),
    .SLOPE_INIT(SLOPE_INIT), .SLOPE_MIN(SLOPE_MIN), .SLOPE_MAX(SLOPE_MAX)
  ) u_loop (
    .clk(clk), .rst(rst), .accept(accept), .peak(ramp_out), .slope(slope_q)
  );

  always_ff @(posedge clk) begin
    if (rst) fs_q <= 1'b0;
    else     fs_q <= accept;
  end

  assign field_start = fs_q;
endmodule

// File: rtl/vramp_trig_chk.sv
module vramp_trig_chk #(
  parameter int unsigned RAMP_W    = 16,
  parameter int unsigned SLOPE_W   = 10,
  parameter int unsigned BLANK_CYC = 1100,
  parameter int unsigned SLOPE_MIN = 1,
  parameter int unsigned SLOPE_MAX = 1023
) (
  input logic               clk,
  input logic               rst,
  input logic               trig_ok,
  input logic               blank,
  input logic               field_start,
  input logic [RAMP_W-1:0]  ramp,
  input logic [SLOPE_W-1:0] slope
);
  localparam int unsigned BW = $clog2(BLANK_CYC + 2) + 1;

  // Length of the current blanking run, for the width check.
  logic [BW-1:0] bcnt;
  always_ff @(posedge clk) begin
    if (rst)        bcnt <= '0;
    else if (blank) bcnt <= bcnt + BW'(1);
    else            bcnt <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (ramp == '0 && !blank && !field_start));

  a_r2_ramp_nondec: assert property (@(posedge clk) disable iff (rst)
    (!trig_ok && !blank) |=> (ramp >= $past(ramp)));

  a_r3_accept_effect: assert property (@(posedge clk) disable iff (rst)
    trig_ok |=> (field_start && blank && ramp == '0));

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    field_start |=> !field_start);

  a_r4_ramp_zero_blank: assert property (@(posedge clk) disable iff (rst)
    blank |-> (ramp == '0));

  a_r4_blank_width: assert property (@(posedge clk) disable iff (rst)
    $fell(blank) |-> (bcnt == BW'(BLANK_CYC)));

  a_r5_locked_out: assert property (@(posedge clk) disable iff (rst)
    blank |=> !field_start);

  a_r7_slope_hold: assert property (@(posedge clk) disable iff (rst)
    !trig_ok |=> $stable(slope));

  a_r7_slope_step: assert property (@(posedge clk) disable iff (rst)
    trig_ok |=> (slope == $past(slope) || slope == $past(slope) + SLOPE_W'(1)
                 || slope == $past(slope) - SLOPE_W'(1)));

  a_r8_slope_bounds: assert property (@(posedge clk) disable iff (rst)
    (32'(slope) >= SLOPE_MIN && 32'(slope) <= SLOPE_MAX));
endmodule

bind vramp_trig vramp_trig_chk #(
  .RAMP_W(RAMP_W), .SLOPE_W(SLOPE_W), .BLANK_CYC(BLANK_CYC),
  .SLOPE_MIN(SLOPE_MIN), .SLOPE_MAX(SLOPE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .trig_ok(accept), .blank(blank_out),
  .field_start(field_start), .ramp(ramp_out), .slope(slope_q)
);

// File: tb/sim_vramp_trig.sv
module sim_vramp_trig;
  localparam int CLK_PERIOD = 10;
  localparam int RW    = 12;
  localparam int SW    = 5;
  localparam int BLANK = 8;
  localparam int TGT   = 2000;
  localparam int SINIT = 8;
  localparam int SMIN  = 2;
  localparam int SMAX  = 31;
  localparam int RMAX  = (1 << RW) - 1;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic [RW-1:0] ramp_out;
  logic blank_out, field_start;

  int n_chk = 0, n_bad = 0;
  int exp_slope = SINIT;
  int last_peak = 0, last_used = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vramp_trig #(
    .RAMP_W(RW), .SLOPE_W(SW), .BLANK_CYC(BLANK), .TARGET(TGT),
    .SLOPE_INIT(SINIT), .SLOPE_MIN(SMIN), .SLOPE_MAX(SMAX), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in),
    .ramp_out(ramp_out), .blank_out(blank_out), .field_start(field_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clip(input int v);
    return (v > RMAX) ? RMAX : v;
  endfunction

  // One field: trigger now, then gap cycles of active ramp after blanking.
  task automatic do_field(input int gap, input bit glitch);
    int peak, nxt, e;
    string tag;
    sync_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    peak = int'(ramp_out);
    check(field_start == 1'b0, "R3 strobe early", field_start, 0);
    sync_in = 1'b0;
    last_peak = peak;
    last_used = exp_slope;
    if (peak < TGT)      nxt = (exp_slope < SMAX) ? exp_slope + 1 : SMAX;
    else if (peak > TGT) nxt = (exp_slope > SMIN) ? exp_slope - 1 : SMIN;
    else                 nxt = exp_slope;
    @(negedge clk);
    check(field_start == 1'b1, "R3 strobe", field_start, 1);
    check(blank_out == 1'b1, "R4 blank rise", blank_out, 1);
    check(ramp_out == '0, "R4 flyback", ramp_out, 0);
    exp_slope = nxt;
    if (glitch) sync_in = 1'b1;
    for (int k = 1; k < BLANK; k++) begin
      @(negedge clk);
      sync_in = 1'b0;
      check(field_start == 1'b0, glitch ? "R5 no strobe" : "R3 single", field_start, 0);
      check(blank_out == 1'b1, glitch ? "R5 blank held" : "R4 blank held", blank_out, 1);
      check(ramp_out == '0, "R4 ramp zero", ramp_out, 0);
    end
    for (int j = 0; j < gap; j++) begin
      @(negedge clk);
      e = clip(j * exp_slope);
      tag = (j != 1) ? "R6 ramp" : ((exp_slope == SMIN || exp_slope == SMAX) ? "R8 slope" : "R7 slope");
      if (j == 0) check(blank_out == 1'b0, glitch ? "R5 blank end" : "R4 blank end", blank_out, 0);
      check(int'(ramp_out) == e, tag, ramp_out, e);
      check(field_start == 1'b0, "R3 quiet", field_start, 0);
    end
  endtask

  task automatic check_settled(input string tag);
    int d;
    d = last_peak - TGT;
    if (d < 0) d = -d;
    check(d <= last_used, tag, last_peak, TGT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ramp_out == '0, "R1 ramp", ramp_out, 0);
    check(blank_out == 1'b0, "R1 blank", blank_out, 0);
    check(field_start == 1'b0, "R1 strobe", field_start, 0);
    rst = 1'b0;
    // R2: free run with no trigger, saturating at full scale
    for (int k = 1; k <= 600; k++) begin
      @(negedge clk);
      check(int'(ramp_out) == clip(k * SINIT), "R2 free run", ramp_out, clip(k * SINIT));
      check(blank_out == 1'b0, "R2 no blank", blank_out, 0);
    end
    // settle at one field rate
    for (int f = 0; f < 5; f++) do_field(249, 1'b0);
    check_settled("R9 rate A");
    // short fields drive slope to its upper limit (R8), one glitch field (R5)
    for (int f = 0; f < 30; f++) do_field(20, f == 2);
    check(exp_slope == SMAX, "R8 top", exp_slope, SMAX);
    // long fields drive slope to its lower limit (R8)
    for (int f = 0; f < 35; f++) do_field(1200, f == 7);
    check(exp_slope == SMIN, "R8 bottom", exp_slope, SMIN);
    // settle at a second field rate, then back at the first
    for (int f = 0; f < 25; f++) do_field(99, 1'b0);
    check_settled("R9 rate B");
    for (int f = 0; f < 20; f++) do_field(249, 1'b0);
    check_settled("R9 rate A again");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule